// File: doc/BRIEF.md
# Stipple and Blit Engine

This block turns 32-bit bus writes into pixel operations on a frame plane that holds one byte per pixel. There are two windows: one for stipple commands and one for blit commands. Each window is split into 8-byte slots. The half of a slot with address bit 2 clear is a colour register. Writing it only latches a pending colour. The half with address bit 2 set issues a command, and the slot number is the destination pixel index.

A stipple command takes its 32-bit data word as a bit mask. Every set bit paints one pixel with the latched colour byte; pixels under clear bits are left alone. A blit command carries a 24-bit source index and a run length of 1 to 32 pixels. When the source field is all ones, the run is filled with the colour byte. Otherwise the run is copied from source to destination, one pixel at a time in ascending order.

The engine drives a single-port synchronous pixel memory and raises `busy` while a command runs. A second command written during that time is held off through `bus_ready`. Colour writes are never held off. Reads of either window return zero.

Top module: `sbe_engine`

## Requirements
- R1: A write with word-address bit 2 (`bus_addr[2]`) clear latches `bus_wdata[7:0]` as the pending colour. It causes no memory access and is accepted in the same cycle, even while a command runs.
- R2: A write with `bus_addr[2]` set is a command. Its destination pixel index is `bus_addr[22:3]`.
- R3: A stipple command (`bus_sel_blit` = 0) writes the colour byte to destination + i for each set data bit 31−i. Pixels under clear bits get no memory write. The command is busy for exactly 32 cycles.
- R4: For a blit command (`bus_sel_blit` = 1), data bits 23:0 are the source index and bits 28:24 are the run length minus one. Bits 31:29 are ignored.
- R5: A blit source of 0xFFFFFF fills the run with the colour byte. It makes one write per pixel and is busy for as many cycles as the run has pixels.
- R6: Any other blit source copies the run pixel by pixel in ascending order, with one read followed by one write per pixel. The command is busy for twice the run length, and an overlapping copy gives the result of that order.
- R7: Destination and source pixel indices wrap modulo 2^20. Source bits 23:20 do not select a pixel.
- R8: `bus_rdata` reads as zero at all times.
- R9: A command write while `busy` is high sees `bus_ready` low until `busy` falls, and is accepted in that cycle.
- R10: A command uses the colour latched when it was accepted. A colour write during the command affects only later commands.
- R11: After reset, `busy` is low, `bus_ready` is high, no memory access is made and the pending colour is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_sel_blit | input | 1 | 0 selects the stipple window, 1 the blit window |
| bus_addr | input | 21 | Word address within the window, bits 22:2 |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Write accepted this cycle when high |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | A command is executing |
| mem_en | output | 1 | Pixel memory access enable |
| mem_we | output | 1 | Pixel memory write enable |
| mem_addr | output | 20 | Pixel index |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data, valid the cycle after a read |

## Verification
A command accepted at one clock edge raises `busy` from that edge. Its first memory operation lands on the next edge. `busy` falls 32 edges later for a stipple, L edges later for a fill and 2L edges later for a copy of L pixels. A colour write takes effect at its own edge. The bench drives and samples only on falling edges. It counts the falling edges with `busy` high from the acceptance edge onward and compares that count with 32, L or 2L. It compares the pixel memory against its own model only after `busy` has dropped, and it checks stall counts as the number of falling edges on which `bus_ready` was low.

// File: rtl/sbe_pkg.sv
// Shared constants and types for the stipple and blit engine.
// Assumes a 32-bit bus word; run-length and source field widths follow it.
package sbe_pkg;
    localparam int unsigned WORD_W = 32;   // bus data width, also stipple mask width
    localparam int unsigned RUN_W  = 5;    // run length field width (runs of 1..32)
    localparam int unsigned SRC_W  = 24;   // blit source field width

    typedef enum logic [1:0] {
        OP_STIP = 2'd0,
        OP_FILL = 2'd1,
        OP_COPY = 2'd2
    } sbe_op_e;
endpackage

// File: rtl/sbe_cmd_decode.sv
// Bus-side decoder: latches the pending colour from colour-half writes and
// turns command-half writes into a start pulse with decoded fields.
// Assumes the sequencer reports busy; command writes are held off while busy.
module sbe_cmd_decode
    import sbe_pkg::*;
#(
    parameter int unsigned IDX_W = 20,
    parameter int unsigned PIX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_sel_blit,
    input  logic [IDX_W+2:2]     bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 busy,
    output logic                 bus_ready,
    output logic [PIX_W-1:0]     colour_q,
    output logic                 start,
    output sbe_op_e              start_op,
    output logic [IDX_W-1:0]     start_dst,
    output logic [IDX_W-1:0]     start_src,
    output logic [RUN_W-1:0]     start_last,
    output logic [WORD_W-1:0]    start_mask
);
    logic              is_cmd;
    logic [SRC_W-1:0]  src_field;
    logic              is_fill;

    assign is_cmd    = bus_addr[2];
    assign src_field = bus_wdata[SRC_W-1:0];
    assign is_fill   = (src_field == {SRC_W{1'b1}});

    // Hold off command writes while a command runs; colour writes always pass.
    assign bus_ready = !(is_cmd && busy);
    assign start     = bus_wr && is_cmd && !busy;

    // Pending colour register, loaded by colour-half writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_q <= '0;
        end else if (bus_wr && !is_cmd) begin
            colour_q <= bus_wdata[PIX_W-1:0];
        end
    end

    // Field decode for the command carried by this write.
    always_comb begin
        start_dst  = bus_addr[IDX_W+2:3];
        start_src  = src_field[IDX_W-1:0];
        start_mask = bus_wdata;
        if (!bus_sel_blit) begin
            start_op   = OP_STIP;
            start_last = {RUN_W{1'b1}};
        end else begin
            start_op   = is_fill ? OP_FILL : OP_COPY;
            start_last = bus_wdata[SRC_W +: RUN_W];
        end
    end
endmodule

// File: rtl/sbe_sequencer.sv
// Command sequencer: steps one pixel per cycle for stipple and fill, and one
// read then one write per pixel for copy, in ascending order.
// Assumes a single-port memory whose read data is valid the cycle after the
// read and stays valid until the next access.
module sbe_sequencer
    import sbe_pkg::*;
#(
    parameter int unsigned IDX_W = 20,
    parameter int unsigned PIX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  sbe_op_e              start_op,
    input  logic [IDX_W-1:0]     start_dst,
    input  logic [IDX_W-1:0]     start_src,
    input  logic [RUN_W-1:0]     start_last,
    input  logic [WORD_W-1:0]    start_mask,
    input  logic [PIX_W-1:0]     colour,
    output logic                 busy,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [IDX_W-1:0]     mem_addr,
    output logic [PIX_W-1:0]     mem_wdata,
    input  logic [PIX_W-1:0]     mem_rdata
);
    sbe_op_e            op_q;
    logic               busy_q;
    logic               wr_phase_q;
    logic [RUN_W-1:0]   cnt_q;
    logic [RUN_W-1:0]   last_q;
    logic [IDX_W-1:0]   dst_q;
    logic [IDX_W-1:0]   src_q;
    logic [WORD_W-1:0]  mask_q;
    logic [PIX_W-1:0]   col_q;
    logic [IDX_W-1:0]   cur_dst;
    logic [IDX_W-1:0]   cur_src;
    logic               step_pixel;

    assign busy    = busy_q;
    assign cur_dst = dst_q + IDX_W'(cnt_q);
    assign cur_src = src_q + IDX_W'(cnt_q);
    // A pixel completes each cycle, except the read half of a copy.
    assign step_pixel = busy_q && !(op_q == OP_COPY && !wr_phase_q);

    // Command state: load on start, advance per pixel, finish on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            op_q       <= OP_STIP;
            wr_phase_q <= 1'b0;
            cnt_q      <= '0;
            last_q     <= '0;
            dst_q      <= '0;
            src_q      <= '0;
            mask_q     <= '0;
            col_q      <= '0;
        end else if (start) begin
            busy_q     <= 1'b1;
            op_q       <= start_op;
            wr_phase_q <= 1'b0;
            cnt_q      <= '0;
            last_q     <= start_last;
            dst_q      <= start_dst;
            src_q      <= start_src;
            mask_q     <= start_mask;
            col_q      <= colour;
        end else if (busy_q) begin
            wr_phase_q <= (op_q == OP_COPY) && !wr_phase_q;
            if (step_pixel) begin
                mask_q <= mask_q << 1;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == last_q) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Memory port drive from the current command state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_dst;
        mem_wdata = col_q;
        if (busy_q) begin
            case (op_q)
                OP_STIP: begin
                    mem_en = mask_q[WORD_W-1];
                    mem_we = mask_q[WORD_W-1];
                end
                OP_FILL: begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                end
                OP_COPY: begin
                    mem_en = 1'b1;
                    mem_we = wr_phase_q;
                    if (!wr_phase_q) begin
                        mem_addr = cur_src;
                    end else begin
                        mem_wdata = mem_rdata;
                    end
                end
                default: begin
                    mem_en = 1'b0;
                end
            endcase
        end
    end

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= last_q));

    // R6
    copy_read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && op_q == OP_COPY && mem_we) |-> $past(mem_en && !mem_we));

    // R10
    colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(col_q));
endmodule

// File: rtl/sbe_engine.sv
// Stipple and blit engine top: joins the bus decoder to the sequencer and
// exposes a single-port pixel memory interface.
// Assumes the memory returns read data one cycle after a read access.
module sbe_engine
    import sbe_pkg::*;
#(
    parameter int unsigned IDX_W = 20,
    parameter int unsigned PIX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_sel_blit,
    input  logic [IDX_W+2:2]     bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic                 bus_ready,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 busy,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [IDX_W-1:0]     mem_addr,
    output logic [PIX_W-1:0]     mem_wdata,
    input  logic [PIX_W-1:0]     mem_rdata
);
    logic               start;
    sbe_op_e            start_op;
    logic [IDX_W-1:0]   start_dst;
    logic [IDX_W-1:0]   start_src;
    logic [RUN_W-1:0]   start_last;
    logic [WORD_W-1:0]  start_mask;
    logic [PIX_W-1:0]   colour_q;

    // Both windows read back as zero.
    assign bus_rdata = '0;

    sbe_cmd_decode #(.IDX_W(IDX_W), .PIX_W(PIX_W)) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_sel_blit (bus_sel_blit),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .busy         (busy),
        .bus_ready    (bus_ready),
        .colour_q     (colour_q),
        .start        (start),
        .start_op     (start_op),
        .start_dst    (start_dst),
        .start_src    (start_src),
        .start_last   (start_last),
        .start_mask   (start_mask)
    );

    sbe_sequencer #(.IDX_W(IDX_W), .PIX_W(PIX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (start_op),
        .start_dst  (start_dst),
        .start_src  (start_src),
        .start_last (start_last),
        .start_mask (start_mask),
        .colour     (colour_q),
        .busy       (busy),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    // R9
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R1
    colour_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[2] && !busy) |=> !mem_en);
endmodule

// File: tb/sim_sbe_engine.sv
module sim_sbe_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_sel_blit = 1'b0;
    logic [22:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        busy;
    logic        mem_en;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    int n_acc = 0;
    int n_wr  = 0;
    logic [7:0] ref_col = '0;

    logic [7:0] dmem    [bit [19:0]];
    logic [7:0] ref_mem [bit [19:0]];

    always #10 clk = ~clk;

    sbe_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_blit(bus_sel_blit),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] dflt(input bit [19:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] dut_rd(input bit [19:0] a);
        return dmem.exists(a) ? dmem[a] : dflt(a);
    endfunction

    function automatic logic [7:0] ref_rd(input bit [19:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
    endfunction

    // Pixel memory model: synchronous, one read or write per cycle.
    always @(posedge clk) begin
        if (mem_en) begin
            n_acc++;
            if (mem_we) begin
                n_wr++;
                dmem[mem_addr] = mem_wdata;
            end else begin
                mem_rdata <= dut_rd(mem_addr);
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic bus_write(input logic blit, input logic [19:0] dst,
                             input logic cmd, input logic [31:0] d,
                             output int stalls);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_sel_blit = blit;
        bus_addr = {dst, cmd};
        bus_wdata = d;
        stalls = 0;
        #1;
        while (!bus_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        if (!cmd) ref_col = d[7:0];
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Reference effect of one command, applied in ascending pixel order.
    task automatic ref_apply(input logic blit, input logic [19:0] dst,
                             input logic [31:0] d, input logic [7:0] c);
        int len;
        len = int'(d[28:24]) + 1;
        if (!blit) begin
            for (int i = 0; i < 32; i++)
                if (d[31-i]) ref_mem[dst + 20'(i)] = c;
        end else if (d[23:0] == 24'hFFFFFF) begin
            for (int k = 0; k < len; k++) ref_mem[dst + 20'(k)] = c;
        end else begin
            for (int k = 0; k < len; k++)
                ref_mem[dst + 20'(k)] = ref_rd(d[19:0] + 20'(k));
        end
    endtask

    task automatic mem_check(input string tag);
        int mism;
        mism = 0;
        foreach (ref_mem[k]) begin
            if (dut_rd(k) !== ref_mem[k]) begin
                mism++;
                $display("  pixel %05h dut=%02h model=%02h", k, dut_rd(k), ref_mem[k]);
            end
        end
        foreach (dmem[k]) begin
            if (!ref_mem.exists(k)) begin
                mism++;
                $display("  pixel %05h written but not by model", k);
            end
        end
        check(tag, "mismatching pixels", 64'(mism), 64'd0);
    endtask

    // {blit, dst[19:0], data[31:0], colour[7:0]}
    localparam logic [60:0] VEC [9] = '{
        {1'b0, 20'h00100, 32'hF0F0_0001, 8'h3C},
        {1'b0, 20'h00200, 32'h8000_0000, 8'h11},
        {1'b0, 20'hFFFF0, 32'hFFFF_FFFF, 8'h77},
        {1'b1, 20'h00300, 32'h09FF_FFFF, 8'hA5},
        {1'b1, 20'h00400, 32'h1F00_0100, 8'h00},
        {1'b1, 20'h00101, 32'h0700_0100, 8'h00},
        {1'b1, 20'h00500, 32'h030F_FFFE, 8'h00},
        {1'b1, 20'h00700, 32'hE1F0_0200, 8'h00},
        {1'b1, 20'hFFFFF, 32'hE0FF_FFFF, 8'h42}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int st;
        int dur;
        int acc0;
        int wr0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "busy after reset", 64'(busy), 64'd0);
        check("R11", "ready after reset", 64'(bus_ready), 64'd1);
        check("R11", "no access after reset", 64'(n_acc), 64'd0);
        check("R8", "rdata idle", 64'(bus_rdata), 64'd0);
        // R11 pending colour resets to zero: fill one pixel without a colour write
        bus_write(1'b1, 20'h00A00, 1'b1, 32'h00FF_FFFF, st);
        ref_apply(1'b1, 20'h00A00, 32'h00FF_FFFF, 8'h00);
        wait_idle(dur);
        check("R11", "fill len1 duration", 64'(dur), 64'd1);
        mem_check("R11 R5");

        // Table of commands
        for (int v = 0; v < 9; v++) begin
            logic        blit;
            logic [19:0] dst;
            logic [31:0] d;
            logic [7:0]  c;
            string       tag;
            int          len;
            int          exp_dur;
            int          exp_wr;
            {blit, dst, d, c} = VEC[v];
            len = int'(d[28:24]) + 1;
            if (!blit) begin
                tag = "R3 R2";
                exp_dur = 32;
                exp_wr = $countones(d);
            end else if (d[23:0] == 24'hFFFFFF) begin
                tag = "R5 R4";
                exp_dur = len;
                exp_wr = len;
            end else begin
                tag = "R6 R4";
                exp_dur = 2 * len;
                exp_wr = len;
            end
            if (v == 2 || v == 6 || v == 7 || v == 8) tag = {tag, " R7"};
            bus_write(blit, dst, 1'b0, {24'hABCDEF, c}, st);
            wr0 = n_wr;
            bus_write(blit, dst, 1'b1, d, st);
            ref_apply(blit, dst, d, ref_col);
            wait_idle(dur);
            check(tag, "busy cycles", 64'(dur), 64'(exp_dur));
            check(tag, "write count", 64'(n_wr - wr0), 64'(exp_wr));
            mem_check(tag);
        end

        // R1 colour write while idle touches no pixel
        acc0 = n_acc;
        bus_write(1'b0, 20'h01000, 1'b0, 32'h0000_00C3, st);
        repeat (3) @(negedge clk);
        check("R1", "accesses after colour write", 64'(n_acc - acc0), 64'd0);
        check("R1", "busy after colour write", 64'(busy), 64'd0);

        // R9 stall: second command waits for the first to finish
        bus_write(1'b0, 20'h02000, 1'b1, 32'hAAAA_AAAA, st);
        ref_apply(1'b0, 20'h02000, 32'hAAAA_AAAA, ref_col);
        check("R8", "rdata during command", 64'(bus_rdata), 64'd0);
        bus_write(1'b0, 20'h02000, 1'b1, 32'h5555_5555, st);
        ref_apply(1'b0, 20'h02000, 32'h5555_5555, ref_col);
        check("R9", "stall cycles", 64'(st), 64'd31);
        wait_idle(dur);
        check("R9", "busy cycles after stall", 64'(dur), 64'd32);
        mem_check("R9");

        // R10 colour written mid-command only applies to later commands
        bus_write(1'b0, 20'h03000, 1'b0, 32'h0000_0061, st);
        bus_write(1'b0, 20'h03000, 1'b1, 32'hFFFF_FFFF, st);
        ref_apply(1'b0, 20'h03000, 32'hFFFF_FFFF, 8'h61);
        bus_write(1'b1, 20'h03000, 1'b0, 32'h0000_009E, st);
        check("R1", "colour write stalls while busy", 64'(st), 64'd0);
        check("R10", "still busy after colour write", 64'(busy), 64'd1);
        wait_idle(dur);
        mem_check("R10");
        bus_write(1'b1, 20'h03100, 1'b1, 32'h00FF_FFFF, st);
        ref_apply(1'b1, 20'h03100, 32'h00FF_FFFF, 8'h9E);
        wait_idle(dur);
        mem_check("R10");
        check("R8", "rdata at end", 64'(bus_rdata), 64'd0);

        summary();
        $finish;
    end
endmodule